// File: doc/BRIEF.md
# Nibble-Parallel CRC5 Updater

This block keeps a running 5-bit cyclic redundancy check over a stream of 4-bit words, using the generator x^5 + x^2 + 1. A bit-serial shift register would need four clocks to take in one nibble. This block takes in a whole nibble in one clock. It does so with a flat XOR network that maps the current 5-bit remainder and the incoming word to the next remainder.

The XOR network is not written out by hand. The block elaborates a serial LFSR step as a constant function. It then feeds that function each of the nine one-hot stimuli: five state bits and four data bits, with every other input at zero. Because the CRC update is linear over GF(2), each next-state bit is the XOR of exactly those inputs whose one-hot response sets that bit.

To use it, a client pulses the init strobe at the start of a message. It then presents one word per cycle with the valid strobe high, and reads the remainder on the output after the last word.

Top module: `crc5_nibble_updater`

## Requirements
- R1: The remainder register is 5 bits wide, the data word is 4 bits wide, and the generator is x^5 + x^2 + 1 (feedback constant 5'h05).
- R2: One accepted word moves the remainder to the value that four serial LFSR steps produce. Word bit 3 enters first and bit 0 enters last. Each serial step computes feedback = remainder[4] XOR data bit, shifts the remainder left by one with a zero in, and XORs in 5'h05 when the feedback is 1.
- R3: For state s and word d, the next remainder n is given by:
  - n[0] = s1^s4^d0^d3
  - n[1] = s2^d1
  - n[2] = s1^s3^s4^d0^d2^d3
  - n[3] = s2^s4^d1^d3
  - n[4] = s0^s3^d2
- R4: A rising clock edge with rst_n low loads the remainder with 5'b11111.
- R5: A rising clock edge with crc_init high loads 5'b11111. This takes priority over a word presented with word_vld high in the same cycle.
- R6: On an edge with word_vld low and crc_init low, the remainder holds its value, whatever word_in carries.
- R7: On an edge with word_vld high and crc_init low, the word is absorbed. The new remainder appears on crc_out right after that edge, so one word is taken per cycle.
- R8: The update is linear. Starting from a fixed state, the change that a word causes equals the XOR of the changes caused by each of its set bits alone. An all-zero state with an all-zero word gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset, loads all ones |
| crc_init | input | 1 | Synchronous restart of the remainder to all ones |
| word_vld | input | 1 | High when word_in carries a word to absorb |
| word_in | input | 4 | Data nibble, bit 3 first in serial order |
| crc_out | output | 5 | Current CRC remainder |

## Verification
The bench first drives each of the four one-hot nibbles from the all-ones seed. It compares each change against an all-zero word from the same seed, which isolates every data column of the XOR network and exposes a swapped or missing tap. Random multi-word streams then exercise state-to-state terms across many reachable remainders. These are compared both with a bit-serial LFSR that feeds bit 3 first and with the closed-form equations, so an error in bit ordering and an error in a single term are each caught. Idle cycles with changing data, and init asserted together with a valid word, separate the hold and priority rules from the update path.

// File: rtl/crc5n_pkg.sv
// Shared constants for the nibble-parallel CRC5 updater.
// Assumes the generator is given without its top (x^5) term.
package crc5n_pkg;
    localparam int              CRC5_W    = 5;
    localparam int              NIBBLE_W  = 4;
    localparam logic [4:0]      CRC5_POLY = 5'h05;
    localparam logic [4:0]      CRC5_SEED = 5'h1F;
endpackage

// File: rtl/crcpar_xornet.sv
// Combinational next-remainder network for a word-parallel CRC.
// Each output bit XORs the inputs whose one-hot response, taken from an
// elaborated serial LFSR, sets that bit (superposition over GF(2)).
// Assumes word bit DATA_W-1 is the first bit in serial order.
module crcpar_xornet #(
    parameter int                 CRC_W  = 5,
    parameter int                 DATA_W = 4,
    parameter logic [CRC_W-1:0]   POLY   = 5'h05
) (
    input  logic [CRC_W-1:0]  state_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [CRC_W-1:0]  next_o
);
    localparam int IN_W = CRC_W + DATA_W;

    // Serial LFSR walk over one word, MSB first; used only at elaboration.
    function automatic logic [CRC_W-1:0] serial_walk(
        input logic [CRC_W-1:0]  s,
        input logic [DATA_W-1:0] d
    );
        logic [CRC_W-1:0] r;
        logic             fb;
        r = s;
        for (int b = DATA_W - 1; b >= 0; b--) begin
            fb = r[CRC_W-1] ^ d[b];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ POLY;
        end
        return r;
    endfunction

    logic [IN_W-1:0]             in_vec;
    logic [CRC_W-1:0][IN_W-1:0]  tap;

    assign in_vec = {word_i, state_i};

    // One-hot responses form the columns of the tap matrix.
    for (genvar k = 0; k < IN_W; k++) begin : g_col
        localparam logic [IN_W-1:0]  ONEHOT = {{(IN_W-1){1'b0}}, 1'b1} << k;
        localparam logic [CRC_W-1:0] RESP   =
            serial_walk(ONEHOT[CRC_W-1:0], ONEHOT[IN_W-1:CRC_W]);
        for (genvar i = 0; i < CRC_W; i++) begin : g_row
            assign tap[i][k] = RESP[i];
        end
    end

    // Each next-state bit is the parity of its selected inputs.
    for (genvar i = 0; i < CRC_W; i++) begin : g_out
        assign next_o[i] = ^(in_vec & tap[i]);
    end

    // Spot checks of the derived network against closed-form terms.
    always_comb begin
        // R8
        if (state_i == '0 && word_i == '0) begin
            zero_in_zero_out_chk: assert (next_o == '0);
        end
        if (CRC_W == 5 && DATA_W == 4 && POLY == 5'h05) begin
            // R3
            bit1_terms_chk: assert (next_o[1] == (state_i[2] ^ word_i[1]));
            // R3
            bit4_terms_chk: assert (next_o[4] == (state_i[0] ^ state_i[3] ^ word_i[2]));
        end
    end
endmodule

// File: rtl/crcpar_state_reg.sv
// Remainder register for the parallel CRC. It loads SEED on reset or init
// (init wins over a load) and otherwise takes next_i only when load_i is high.
// Assumes reset and init are sampled synchronously.
module crcpar_state_reg #(
    parameter int               W    = 5,
    parameter logic [W-1:0]     SEED = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_i,
    input  logic         load_i,
    input  logic [W-1:0] next_i,
    output logic [W-1:0] crc_q
);
    // Remainder update: seed, absorb or hold.
    always_ff @(posedge clk) begin
        if (!rst_n || init_i) crc_q <= SEED;
        else if (load_i)      crc_q <= next_i;
    end

    // R6
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !load_i) |=> $stable(crc_q));
    // R5
    init_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (crc_q == SEED));
    // R7
    load_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !init_i) |=> (crc_q == $past(next_i)));
endmodule

// File: rtl/crc5_nibble_updater.sv
// Top of the nibble-parallel CRC5 updater (x^5 + x^2 + 1, seed all ones).
// Absorbs one 4-bit word per clock when word_vld is high.
// Assumes word_in bit 3 is the earliest bit in serial order.
module crc5_nibble_updater
    import crc5n_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 crc_init,
    input  logic                 word_vld,
    input  logic [NIBBLE_W-1:0]  word_in,
    output logic [CRC5_W-1:0]    crc_out
);
    logic [CRC5_W-1:0] next_rem;

    // R1: width and generator come from the package constants.
    crcpar_xornet #(
        .CRC_W  (CRC5_W),
        .DATA_W (NIBBLE_W),
        .POLY   (CRC5_POLY)
    ) xornet_i (
        .state_i (crc_out),
        .word_i  (word_in),
        .next_o  (next_rem)
    );

    crcpar_state_reg #(
        .W    (CRC5_W),
        .SEED (CRC5_SEED)
    ) rem_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_i (crc_init),
        .load_i (word_vld),
        .next_i (next_rem),
        .crc_q  (crc_out)
    );
endmodule

// File: tb/crc5_nibble_updater_tb_top.sv
// Directed bench: serial LFSR reference plus closed-form equations.
module crc5_nibble_updater_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       crc_init = 1'b0;
    logic       word_vld = 1'b0;
    logic [3:0] word_in = 4'h0;
    logic [4:0] crc_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [4:0] model = 5'h1F;

    always #4 clk = ~clk;

    crc5_nibble_updater dut_i (
        .clk(clk), .rst_n(rst_n), .crc_init(crc_init),
        .word_vld(word_vld), .word_in(word_in), .crc_out(crc_out)
    );

    // R1 R2: bit-serial reference, bit 3 first, feedback constant 5'h05.
    function automatic logic [4:0] ser_ref(input logic [4:0] s, input logic [3:0] d);
        logic [4:0] r = s;
        logic fb;
        for (int b = 3; b >= 0; b--) begin
            fb = r[4] ^ d[b];
            r  = {r[3:0], 1'b0};
            if (fb) r = r ^ 5'h05;
        end
        return r;
    endfunction

    // R3 closed-form equations.
    function automatic logic [4:0] eq_ref(input logic [4:0] s, input logic [3:0] d);
        eq_ref[0] = s[1]^s[4]^d[0]^d[3];
        eq_ref[1] = s[2]^d[1];
        eq_ref[2] = s[1]^s[3]^s[4]^d[0]^d[2]^d[3];
        eq_ref[3] = s[2]^s[4]^d[1]^d[3];
        eq_ref[4] = s[0]^s[3]^d[2];
    endfunction

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Absorb one word and check it against both references (R2 R3 R7).
    task automatic send_word(input logic [3:0] d);
        logic [4:0] pre = model;
        @(negedge clk); word_in = d; word_vld = 1'b1;
        @(negedge clk); word_vld = 1'b0;
        model = ser_ref(pre, d);
        check("R2/R7 serial match", crc_out, model);
        check("R3 equations", crc_out, eq_ref(pre, d));
    endtask

    task automatic do_init();
        @(negedge clk); crc_init = 1'b1;
        @(negedge clk); crc_init = 1'b0;
        model = 5'h1F;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model = 5'h1F;
        check("R4 reset seed", crc_out, 5'h1F);
    endtask

    // R8: one-hot columns superpose; R1 width via known column values.
    task automatic t_onehot();
        logic [4:0] base;
        logic [4:0] acc = 5'h00;
        do_init(); send_word(4'h0); base = crc_out;
        check("R8 seed with zero word", base, ser_ref(5'h1F, 4'h0));
        for (int k = 0; k < 4; k++) begin
            do_init(); send_word(4'(1 << k));
            check("R8 one-hot column", crc_out ^ base, ser_ref(5'h00, 4'(1 << k)));
            acc = acc ^ crc_out ^ base;
        end
        do_init(); send_word(4'hF);
        check("R8 superposition", crc_out ^ base, acc);
        check("R1 column for bit 0", ser_ref(5'h00, 4'h1), 5'h05);
    endtask

    // R6: idle cycles with changing data leave the remainder alone.
    task automatic t_hold();
        logic [4:0] held;
        send_word(4'hA);
        held = crc_out;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); word_in = 4'(i * 5 + 3);
            check("R6 hold when idle", crc_out, held);
        end
        @(negedge clk);
        check("R6 hold after idle", crc_out, held);
    endtask

    // R5: init and valid together seed the register.
    task automatic t_init_prio();
        send_word(4'h3); send_word(4'h9);
        @(negedge clk); crc_init = 1'b1; word_vld = 1'b1; word_in = 4'h6;
        @(negedge clk); crc_init = 1'b0; word_vld = 1'b0;
        model = 5'h1F;
        check("R5 init over valid", crc_out, 5'h1F);
    endtask

    // R2 R7: random back-to-back and gapped streams.
    task automatic t_stream(input int len, input bit gaps);
        logic [3:0] d;
        do_init();
        for (int i = 0; i < len; i++) begin
            d = 4'($urandom_range(0, 15));
            @(negedge clk); word_in = d; word_vld = 1'b1;
            @(posedge clk); model = ser_ref(model, d);
            if (gaps && (i % 3 == 0)) begin
                @(negedge clk); word_vld = 1'b0;
            end
        end
        @(negedge clk); word_vld = 1'b0;
        check("R7 stream result", crc_out, model);
    endtask

    // R4: reset in mid stream restores the seed.
    task automatic t_reset_mid();
        send_word(4'h5);
        t_reset();
        send_word(4'hC);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_onehot();
        t_hold();
        t_init_prio();
        for (int r = 0; r < 20; r++) t_stream(8 + r, r[0]);
        for (int r = 0; r < 30; r++) send_word(4'($urandom_range(0, 15)));
        t_reset_mid();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule